// File: doc/BRIEF.md
# DV Frame Timestamp Generator

This block produces the 16-bit presentation timestamp that a DV transmit stream carries in the SYT field of each packet's header. A frame-sync input from the video source marks the start of each frame. On its rising edge the block takes the current bus cycle timer and adds a programmable transmit offset. The addition follows the cycle timer's own arithmetic: the upper 4 bits count isochronous cycles, and the lower 12 bits count ticks within a cycle modulo 3072.

The timestamp is held until the packet stream reaches a packet that may carry it. A mode bit picks that packet. It is either the start-of-frame packet, whether empty or full, or the first full packet of the frame that begins at that start-of-frame packet. For every packet the block returns a value: the timestamp with an insert strobe for the chosen packet, and the no-information code 0xFFFF for all others. The packet assembler uses this value in the next cycle.

Top module: `dvts_syt_gen`

## Requirements
- R1: After reset, `syt_out` is 0xFFFF, `syt_insert` is low, and no timestamp is pending, so a start-of-frame packet sent before any frame-sync edge gets 0xFFFF.
- R2: The timestamp is the captured timer plus the offset. Bits [15:12] are the cycle count and bits [11:0] are the tick. When the two ticks add to less than 3072, the tick is that sum and the cycle is the sum of the two cycle fields.
- R3: When the two ticks add to 3072 or more, the tick is the sum minus 3072 and one is added to the cycle field.
- R4: The cycle field wraps modulo 16.
- R5: Each rising edge of `frame_sync` captures exactly one timestamp. Holding the input high or letting it fall captures nothing further.
- R6: With `place_full_only`=0, the first packet with `pkt_sof`=1 after a capture receives the timestamp, whether that packet is empty or full.
- R7: With `place_full_only`=1, the timestamp goes to the first packet with `pkt_full`=1. This may be the start-of-frame packet itself or a later packet of the same frame. The search starts only at a start-of-frame packet seen after the capture.
- R8: Every packet that does not receive the timestamp gets `syt_out`=0xFFFF with `syt_insert`=0.
- R9: Once a timestamp is inserted, it is consumed and never inserted again.
- R10: A new capture that happens before the pending timestamp is inserted replaces it.
- R11: Results are registered. They appear in the cycle after the clock edge that samples `pkt_valid`, and `syt_insert` never rises without a packet.
- R12: The timer value sampled at capture is the one used. Later changes to `cyc_timer` or `tx_offset` do not alter a pending timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_timer | input | 16 | Bus cycle timer: cycle count in [15:12], tick (0..3071) in [11:0] |
| tx_offset | input | 16 | Transmit offset in the same format |
| frame_sync | input | 1 | Asynchronous frame-start input; the rising edge is used |
| place_full_only | input | 1 | 0: use the start-of-frame packet; 1: use the first full packet |
| pkt_valid | input | 1 | One-cycle strobe for each packet that is about to be sent |
| pkt_sof | input | 1 | The packet opens a frame |
| pkt_full | input | 1 | The packet carries data (not empty) |
| syt_out | output | 16 | SYT value for the packet strobed in the previous cycle |
| syt_insert | output | 1 | `syt_out` holds a real timestamp |

## Verification
The bench builds the block with its default parameters: a 4-bit cycle field, a 12-bit tick field, a modulus of 3072 and a two-stage synchronizer. With these values, tick sums near 6142 and cycle sums that wrap past 15 can be reached with a handful of captures. Expected timestamps come from a flat tick-count model taken modulo 16×3072, which is independent of the split carry logic. Packet sequences in both placement modes cover stale, overwritten and held-high frame-sync cases.

// File: rtl/dvts_pkg.sv
// Package: shared widths and constants for the DV frame timestamp generator.
// Assumes a cycle timer split into a cycle count (upper) and a tick (lower).
package dvts_pkg;
    localparam int unsigned CYC_W_DEF   = 4;
    localparam int unsigned TICK_W_DEF  = 12;
    localparam int unsigned TICK_MOD_DEF = 3072;
    localparam int unsigned SYNC_N_DEF  = 2;
endpackage

// File: rtl/dvts_edge_sync.sv
// Module: brings the asynchronous frame-sync input into the clock domain
// through a flop chain and emits a one-cycle pulse on its rising edge.
// Assumes the input stays high or low for longer than SYNC_N+1 clocks.
module dvts_edge_sync #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int unsigned CHAIN_W = SYNC_N + 1;

    logic [CHAIN_W-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < CHAIN_W; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: first sampling flop of the synchronizer.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                // Purpose: later synchronizer / history stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Purpose: rising edge seen between the last two stages.
    always_comb begin
        rise_pulse = chain_q[SYNC_N-1] & ~chain_q[SYNC_N];
    end

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse); // R5
endmodule

// File: rtl/dvts_cyc_add.sv
// Module: adds two cycle-timer values using cycle-timer arithmetic.
// The tick fields are summed one bit wider, corrected by TICK_MOD with a carry
// into the cycle field, and the cycle field wraps at 2**CYC_W.
// Assumes both tick inputs are below TICK_MOD.
module dvts_cyc_add #(
    parameter int unsigned CYC_W    = 4,
    parameter int unsigned TICK_W   = 12,
    parameter int unsigned TICK_MOD = 3072
) (
    input  logic clk,
    input  logic rst_n,
    input  logic [CYC_W+TICK_W-1:0] a_in,
    input  logic [CYC_W+TICK_W-1:0] b_in,
    output logic [CYC_W+TICK_W-1:0] sum_out
);
    localparam int unsigned WIDE_W = TICK_W + 1;
    localparam logic [WIDE_W-1:0] MOD_W = WIDE_W'(TICK_MOD);

    logic [WIDE_W-1:0] tick_raw;
    logic              tick_carry;
    logic [WIDE_W-1:0] tick_fix;
    logic [CYC_W-1:0]  cyc_sum;

    // Purpose: wide tick sum, carry decision and modular correction.
    always_comb begin
        tick_raw   = {1'b0, a_in[TICK_W-1:0]} + {1'b0, b_in[TICK_W-1:0]};
        tick_carry = (tick_raw >= MOD_W);
        tick_fix   = tick_carry ? (tick_raw - MOD_W) : tick_raw;
    end

    // Purpose: cycle-field sum including the tick carry, wrapping naturally.
    always_comb begin
        cyc_sum = a_in[CYC_W+TICK_W-1:TICK_W] + b_in[CYC_W+TICK_W-1:TICK_W]
                + {{(CYC_W-1){1'b0}}, tick_carry};
        sum_out = {cyc_sum, tick_fix[TICK_W-1:0]};
    end

    AST_TICK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_in[TICK_W-1:0] < TICK_W'(TICK_MOD)) && (b_in[TICK_W-1:0] < TICK_W'(TICK_MOD)))
        |-> (sum_out[TICK_W-1:0] < TICK_W'(TICK_MOD))); // R3
endmodule

// File: rtl/dvts_place_ctrl.sv
// Module: holds the latest captured timestamp and selects the packet that
// receives it. Mode 0 uses the start-of-frame packet; mode 1 starts a search
// at a start-of-frame packet and takes the first full packet of that frame.
// Results are registered one cycle after the packet strobe; every other
// packet receives the all-ones no-information code.
module dvts_place_ctrl #(
    parameter int unsigned SYT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_strobe,
    input  logic [SYT_W-1:0] cap_value,
    input  logic             full_only,
    input  logic             pkt_valid,
    input  logic             pkt_sof,
    input  logic             pkt_full,
    output logic [SYT_W-1:0] syt_out,
    output logic             syt_insert
);
    localparam logic [SYT_W-1:0] SYT_NONE = '1;

    logic             pend_q;
    logic [SYT_W-1:0] pend_val_q;
    logic             hunt_q;
    logic             sof_hit;
    logic             later_hit;
    logic             take;

    // Purpose: decide whether the current packet takes the pending value.
    always_comb begin
        sof_hit   = pkt_sof && (!full_only || pkt_full);
        later_hit = !pkt_sof && hunt_q && full_only && pkt_full;
        take      = pkt_valid && pend_q && (sof_hit || later_hit);
    end

    // Purpose: pending timestamp store; a capture overrides consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            pend_val_q <= SYT_NONE;
        end else if (cap_strobe) begin
            pend_q     <= 1'b1;
            pend_val_q <= cap_value;
        end else if (take) begin
            pend_q     <= 1'b0;
        end
    end

    // Purpose: full-only search window opened by a start-of-frame packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hunt_q <= 1'b0;
        else if (cap_strobe || take)
            hunt_q <= 1'b0;
        else if (pkt_valid && pkt_sof && pend_q && full_only)
            hunt_q <= 1'b1;
    end

    // Purpose: registered per-packet SYT result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syt_out    <= SYT_NONE;
            syt_insert <= 1'b0;
        end else begin
            syt_out    <= take ? pend_val_q : SYT_NONE;
            syt_insert <= take;
        end
    end

    AST_INSERT_HAS_PKT: assert property (@(posedge clk) disable iff (!rst_n)
        syt_insert |-> $past(pkt_valid)); // R11
    AST_NONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !syt_insert |-> (syt_out == SYT_NONE)); // R8
    AST_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !cap_strobe) |=> !pend_q); // R9
    AST_CAPTURE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_strobe |=> (pend_q && pend_val_q == $past(cap_value))); // R10
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !cap_strobe) |=> $stable(pend_val_q)); // R12
endmodule

// File: rtl/dvts_syt_gen.sv
// Module (top): DV frame timestamp generator. A synchronized frame-sync rising
// edge captures cycle_timer + tx_offset (cycle-timer arithmetic); the value is
// delivered to the packet chosen by place_full_only.
// Assumes tick fields of both inputs are below TICK_MOD.
module dvts_syt_gen
    import dvts_pkg::*;
#(
    parameter int unsigned CYC_W    = CYC_W_DEF,
    parameter int unsigned TICK_W   = TICK_W_DEF,
    parameter int unsigned TICK_MOD = TICK_MOD_DEF,
    parameter int unsigned SYNC_N   = SYNC_N_DEF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CYC_W+TICK_W-1:0] cyc_timer,
    input  logic [CYC_W+TICK_W-1:0] tx_offset,
    input  logic                    frame_sync,
    input  logic                    place_full_only,
    input  logic                    pkt_valid,
    input  logic                    pkt_sof,
    input  logic                    pkt_full,
    output logic [CYC_W+TICK_W-1:0] syt_out,
    output logic                    syt_insert
);
    localparam int unsigned SYT_W = CYC_W + TICK_W;

    logic             fs_rise;
    logic [SYT_W-1:0] stamp_sum;

    dvts_edge_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (frame_sync),
        .rise_pulse (fs_rise)
    );

    dvts_cyc_add #(.CYC_W(CYC_W), .TICK_W(TICK_W), .TICK_MOD(TICK_MOD)) u_add (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_in    (cyc_timer),
        .b_in    (tx_offset),
        .sum_out (stamp_sum)
    );

    dvts_place_ctrl #(.SYT_W(SYT_W)) u_place (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_strobe (fs_rise),
        .cap_value  (stamp_sum),
        .full_only  (place_full_only),
        .pkt_valid  (pkt_valid),
        .pkt_sof    (pkt_sof),
        .pkt_full   (pkt_full),
        .syt_out    (syt_out),
        .syt_insert (syt_insert)
    );
endmodule

// File: tb/dvts_syt_gen_tb_top.sv
// Scoreboard bench: the packet driver pushes expected results into a queue,
// and a monitor pops them one cycle later and compares them with the outputs.
module dvts_syt_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MODV = 3072;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cyc_timer = '0;
    logic [15:0] tx_offset = '0;
    logic        frame_sync = 1'b0;
    logic        place_full_only = 1'b0;
    logic        pkt_valid = 1'b0;
    logic        pkt_sof = 1'b0;
    logic        pkt_full = 1'b0;
    logic [15:0] syt_out;
    logic        syt_insert;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic        ins;
        logic [15:0] syt;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dvts_syt_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_timer(cyc_timer), .tx_offset(tx_offset),
        .frame_sync(frame_sync), .place_full_only(place_full_only),
        .pkt_valid(pkt_valid), .pkt_sof(pkt_sof), .pkt_full(pkt_full),
        .syt_out(syt_out), .syt_insert(syt_insert)
    );

    // Reference: flat tick count modulo 16 cycles.
    function automatic logic [15:0] ref_stamp(input logic [15:0] t, input logic [15:0] o);
        int tot;
        tot = (int'(t[15:12]) * MODV + int'(t[11:0])) + (int'(o[15:12]) * MODV + int'(o[11:0]));
        tot = tot % (16 * MODV);
        return {4'(tot / MODV), 12'(tot % MODV)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_pkt(input bit sof, input bit full, input bit ins, input logic [15:0] syt, input string tag);
        exp_t e;
        @(negedge clk);
        pkt_valid = 1'b1; pkt_sof = sof; pkt_full = full;
        e.ins = ins; e.syt = syt; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        pkt_valid = 1'b0; pkt_sof = 1'b0; pkt_full = 1'b0;
    endtask

    task automatic raise_sync(input logic [15:0] t, input logic [15:0] o);
        @(negedge clk);
        cyc_timer = t; tx_offset = o; frame_sync = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic drop_sync();
        @(negedge clk);
        frame_sync = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Monitor: compares after each edge, away from the edge itself.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (sb_q.size() > 0) begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(syt_insert == e.ins && syt_out == e.syt, e.tag,
                          {15'd0, syt_insert, syt_out}, {15'd0, e.ins, e.syt});
                end else if (syt_insert !== 1'b0) begin
                    check(1'b0, "R11 insert without packet", {31'd0, syt_insert}, 32'd0);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] s;
        repeat (3) @(negedge clk);
        check(syt_out == 16'hFFFF && syt_insert == 1'b0, "R1 reset outputs",
              {15'd0, syt_insert, syt_out}, {16'd0, 16'hFFFF});
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        send_pkt(1, 1, 0, 16'hFFFF, "R1 nothing pending after reset");

        // R2 + R6: no carry, empty start-of-frame packet, any-packet mode.
        s = ref_stamp(16'h1100, 16'h2200);
        raise_sync(16'h1100, 16'h2200);
        send_pkt(0, 1, 0, 16'hFFFF, "R8 non-sof packet before frame");
        send_pkt(1, 0, 1, s, "R2 R6 no-carry stamp on empty sof");
        send_pkt(1, 1, 0, 16'hFFFF, "R9 stamp consumed");
        drop_sync();

        // R3: tick carry.
        s = ref_stamp(16'h2BB8, 16'h31F4);
        raise_sync(16'h2BB8, 16'h31F4);
        send_pkt(1, 1, 1, s, "R3 carry into cycle field");
        drop_sync();

        // R4: cycle wrap with carry, extreme ticks 3071+3071.
        s = ref_stamp(16'hFBFF, 16'h1BFF);
        raise_sync(16'hFBFF, 16'h1BFF);
        send_pkt(1, 1, 1, s, "R4 cycle field wraps");
        drop_sync();

        // R7: full-only placement.
        place_full_only = 1'b1;
        s = ref_stamp(16'h0005, 16'h0010);
        raise_sync(16'h0005, 16'h0010);
        send_pkt(0, 1, 0, 16'hFFFF, "R7 full packet before sof ignored");
        send_pkt(1, 0, 0, 16'hFFFF, "R7 empty sof skipped");
        send_pkt(0, 0, 0, 16'hFFFF, "R8 empty non-sof");
        send_pkt(0, 1, 1, s, "R7 first full packet of frame");
        send_pkt(0, 1, 0, 16'hFFFF, "R9 next full packet gets none");
        drop_sync();
        s = ref_stamp(16'h0300, 16'h0001);
        raise_sync(16'h0300, 16'h0001);
        send_pkt(1, 1, 1, s, "R7 full sof takes stamp");
        drop_sync();
        place_full_only = 1'b0;

        // R12: change the inputs after the capture.
        s = ref_stamp(16'h4123, 16'h0456);
        raise_sync(16'h4123, 16'h0456);
        cyc_timer = 16'h9999; tx_offset = 16'h0777;
        repeat (3) @(negedge clk);
        send_pkt(1, 0, 1, s, "R12 captured value kept");
        drop_sync();

        // R10: overwrite before insertion.
        raise_sync(16'h0111, 16'h0222);
        drop_sync();
        s = ref_stamp(16'h7800, 16'h0900);
        raise_sync(16'h7800, 16'h0900);
        send_pkt(1, 1, 1, s, "R10 newer capture wins");

        // R5: held high, then falling: no further capture.
        repeat (6) @(negedge clk);
        send_pkt(1, 1, 0, 16'hFFFF, "R5 held high no recapture");
        drop_sync();
        send_pkt(1, 1, 0, 16'hFFFF, "R5 falling edge no capture");

        // R11: idle cycles after a capture show no insert.
        s = ref_stamp(16'h0ABC, 16'h0001);
        raise_sync(16'h0ABC, 16'h0001);
        repeat (5) @(negedge clk);
        send_pkt(1, 0, 1, s, "R11 registered result after strobe");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule